// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches the single tearing-effect pin of a display panel. That one pin carries both the horizontal and the vertical sync, and the block tells them apart by pulse width. The pin is first passed through a synchronizer. The block then measures how long each level is held, in clock ticks. When an active-level run ends, the block decides whether it was a vertical sync, a horizontal sync or a glitch that must be ignored.

A line counter restarts at every vertical sync and steps on every horizontal sync. A one-cycle, active-low match pulse is produced either on every vertical sync or when the line count reaches a programmed target. DMA or interrupt logic uses the falling edge of that pulse to release a frame transfer that has been held back. The configuration pins set the polarity of each sync, the two width thresholds, the target line, the mode and a master enable. They are expected to stay steady while the display is sending pulses.

Top module: `te_sync_detect`

## Requirements
- R1: While reset is held and just after it, `match_n` is 1, `hsync_evt` and `vsync_evt` are 0 and `cur_line` is 0.
- R2: An active-level vertical pulse whose width is at least (`cfg_vs_width`+1)×8 ticks raises `vsync_evt` for one cycle after the pulse ends. With the 9-bit field this threshold ranges from 8 to 4096.
- R3: A pulse on the horizontal active level raises `hsync_evt` for one cycle after it ends when its width is at least `cfg_hs_width`+1 ticks (3-bit field, 1 to 8). On a shared active level, a pulse that also reaches the vertical threshold counts as vertical only. The two events never occur together.
- R4: An active-level pulse shorter than the horizontal threshold is a glitch. It raises no event, leaves `cur_line` unchanged and produces no match.
- R5: The horizontal sync is active-high when `cfg_hs_inv`=0 and active-low when it is 1. `cfg_vs_inv` sets the vertical sync in the same way. A run on a level that is not active for a sync type never produces an event of that type.
- R6: `cur_line` goes to 0 on a vertical event and rises by one on a horizontal event. It saturates at 2047.
- R7: With `cfg_te_en`=1 and `cfg_mode`=2'b11, every vertical event produces a match and horizontal events produce none.
- R8: With `cfg_te_en`=1 and `cfg_mode`=2'b10, a vertical or horizontal event produces a match when the line count after that event equals `cfg_line`.
- R9: With `cfg_te_en`=0, or with `cfg_mode` equal to 2'b00 or 2'b01, no match is produced. Events and line counting continue.
- R10: Each match drives `match_n` low for exactly one cycle, one cycle after the event strobe.
- R11: The level held from reset until the first transition on the pin is never classified, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Synchronous active-low reset |
| te_pin | input | 1 | Asynchronous tearing-effect pin from the panel |
| cfg_te_en | input | 1 | Master enable for match generation |
| cfg_mode | input | 2 | 00 off, 01 reserved (off), 10 line match, 11 vertical only |
| cfg_hs_inv | input | 1 | Horizontal sync active-low when 1 |
| cfg_vs_inv | input | 1 | Vertical sync active-low when 1 |
| cfg_hs_width | input | HS_FW (3) | Horizontal threshold minus one, in ticks |
| cfg_vs_width | input | VS_FW (9) | Vertical threshold in units of 8 ticks, minus one |
| cfg_line | input | LINE_W (11) | Target line for line-match mode |
| match_n | output | 1 | Active-low one-cycle match pulse |
| hsync_evt | output | 1 | One-cycle strobe for a detected horizontal sync |
| vsync_evt | output | 1 | One-cycle strobe for a detected vertical sync |
| cur_line | output | LINE_W (11) | Lines counted since the last vertical sync |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a 3-bit horizontal field, a 9-bit vertical field and an 11-bit line counter. Because the counter is 11 bits wide, a few thousand short horizontal pulses are enough to drive it into saturation at 2047 and to see repeated matches at that line. The small thresholds (1 to 8 and 8 to 32 ticks) let the tests cover both edges of each threshold exactly, as well as randomized frames that mix glitches, line-match targets and both polarities.

// File: rtl/te_sync_pkg.sv
// Shared definitions for the tearing-effect sync detector.
package te_sync_pkg;

    // Match mode encoding carried on cfg_mode.
    typedef enum logic [1:0] {
        TE_OFF   = 2'b00,
        TE_RSVD  = 2'b01,
        TE_LINE  = 2'b10,
        TE_VSYNC = 2'b11
    } te_mode_e;

    // Log2 of the granule in which the vertical threshold is programmed.
    localparam int unsigned VS_GRAN_SHIFT = 3;

endpackage

// File: rtl/te_pin_sync.sv
// te_pin_sync: brings the asynchronous panel pin into the clock domain
// through a chain of STAGES flops.
// Assumes: STAGES >= 2; the pin idles low during reset.
module te_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_async;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/te_pulse_meter.sv
// te_pulse_meter: measures every run of constant level on the synchronized
// pin and classifies each finished active run as a vertical sync, a
// horizontal sync or a glitch.
// Assumes: the thresholds stay steady while pulses arrive; the first run
// after reset is of unknown length and is never classified.
module te_pulse_meter
    import te_sync_pkg::*;
#(
    parameter int unsigned HS_FW = 3,
    parameter int unsigned VS_FW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             hs_inv,
    input  logic             vs_inv,
    input  logic [HS_FW-1:0] hs_width,
    input  logic [VS_FW-1:0] vs_width,
    output logic             hs_evt,
    output logic             vs_evt
);

    localparam int unsigned CNT_W = VS_FW + VS_GRAN_SHIFT + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             prev_q;
    logic             run_vld_q;
    logic [CNT_W-1:0] run_cnt_q;
    logic [CNT_W-1:0] hs_thr;
    logic [CNT_W-1:0] vs_thr;
    logic             run_end;
    logic             is_vs;
    logic             is_hs;

    // Thresholds in ticks derived from the programmed fields.
    always_comb begin
        hs_thr = CNT_W'(hs_width) + CNT_W'(1);
        vs_thr = (CNT_W'(vs_width) + CNT_W'(1)) << VS_GRAN_SHIFT;
    end

    // Classify the run that ends in this cycle.
    always_comb begin
        run_end = (lvl != prev_q) && run_vld_q;
        is_vs   = run_end && (prev_q == ~vs_inv) && (run_cnt_q >= vs_thr);
        is_hs   = run_end && !is_vs && (prev_q == ~hs_inv) && (run_cnt_q >= hs_thr);
    end

    // Track the current level and the length of its run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            run_cnt_q <= '0;
            run_vld_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (lvl != prev_q) begin
                run_cnt_q <= CNT_W'(1);
                run_vld_q <= 1'b1;
            end else if (run_cnt_q != CNT_MAX) begin
                run_cnt_q <= run_cnt_q + CNT_W'(1);
            end
        end
    end

    // Register the one-cycle event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_evt <= 1'b0;
            vs_evt <= 1'b0;
        end else begin
            hs_evt <= is_hs;
            vs_evt <= is_vs;
        end
    end

endmodule

// File: rtl/te_line_match.sv
// te_line_match: counts lines since the last vertical sync and raises the
// active-low match pulse that the selected mode asks for.
// Assumes: hs_evt and vs_evt are one-cycle strobes that never coincide.
module te_line_match
    import te_sync_pkg::*;
#(
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_evt,
    input  logic              vs_evt,
    input  logic              te_en,
    input  logic [1:0]        mode,
    input  logic [LINE_W-1:0] target,
    output logic [LINE_W-1:0] line,
    output logic              match_n
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [LINE_W-1:0] line_nxt;
    logic              hit;
    te_mode_e          mode_e;

    assign mode_e = te_mode_e'(mode);

    // Next line value: clear on vertical, saturating step on horizontal.
    always_comb begin
        line_nxt = line;
        if (vs_evt)                          line_nxt = '0;
        else if (hs_evt && line != LINE_MAX) line_nxt = line + LINE_W'(1);
    end

    // Decide whether this event satisfies the active mode.
    always_comb begin
        hit = 1'b0;
        if (te_en) begin
            unique case (mode_e)
                TE_VSYNC: hit = vs_evt;
                TE_LINE:  hit = (vs_evt || hs_evt) && (line_nxt == target);
                default:  hit = 1'b0;
            endcase
        end
    end

    // Register the line count and the match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line    <= '0;
            match_n <= 1'b1;
        end else begin
            line    <= line_nxt;
            match_n <= ~hit;
        end
    end

endmodule

// File: rtl/te_sync_detect.sv
// te_sync_detect: top of the tearing-effect sync detector. Synchronizes the
// panel pin, classifies pulses by width and drives the match pulse.
// Assumes: configuration is held steady while the panel sends pulses.
module te_sync_detect #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HS_FW       = 3,
    parameter int unsigned VS_FW       = 9,
    parameter int unsigned LINE_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te_pin,
    input  logic              cfg_te_en,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_hs_inv,
    input  logic              cfg_vs_inv,
    input  logic [HS_FW-1:0]  cfg_hs_width,
    input  logic [VS_FW-1:0]  cfg_vs_width,
    input  logic [LINE_W-1:0] cfg_line,
    output logic              match_n,
    output logic              hsync_evt,
    output logic              vsync_evt,
    output logic [LINE_W-1:0] cur_line
);

    logic pin_s;

    te_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (te_pin),
        .pin_sync  (pin_s)
    );

    te_pulse_meter #(.HS_FW(HS_FW), .VS_FW(VS_FW)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (pin_s),
        .hs_inv   (cfg_hs_inv),
        .vs_inv   (cfg_vs_inv),
        .hs_width (cfg_hs_width),
        .vs_width (cfg_vs_width),
        .hs_evt   (hsync_evt),
        .vs_evt   (vsync_evt)
    );

    te_line_match #(.LINE_W(LINE_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_evt  (hsync_evt),
        .vs_evt  (vsync_evt),
        .te_en   (cfg_te_en),
        .mode    (cfg_mode),
        .target  (cfg_line),
        .line    (cur_line),
        .match_n (match_n)
    );

endmodule

// File: rtl/te_sync_detect_chk.sv
// te_sync_detect_chk: temporal properties of the detector's ports, bound
// to every instance of te_sync_detect.
module te_sync_detect_chk #(
    parameter int unsigned LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_te_en,
    input logic [1:0]        cfg_mode,
    input logic              match_n,
    input logic              hsync_evt,
    input logic              vsync_evt,
    input logic [LINE_W-1:0] cur_line
);

    localparam logic [LINE_W-1:0] LMAX = '1;

    assert_evt_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hsync_evt && vsync_evt));

    assert_match_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !match_n |=> match_n);

    assert_match_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !match_n |-> $past(cfg_te_en && cfg_mode[1]));

    assert_vs_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_evt |=> (cur_line == '0));

    assert_hs_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_evt && cur_line != LMAX) |=> (cur_line == LINE_W'($past(cur_line) + 1'b1)));

    assert_line_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_evt && !vsync_evt) |=> $stable(cur_line));

    assert_vs_mode_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_te_en && cfg_mode == 2'b11 && vsync_evt) |=> !match_n);

endmodule

bind te_sync_detect te_sync_detect_chk #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_te_en (cfg_te_en),
    .cfg_mode  (cfg_mode),
    .match_n   (match_n),
    .hsync_evt (hsync_evt),
    .vsync_evt (vsync_evt),
    .cur_line  (cur_line)
);

// File: tb/te_sync_detect_test.sv
// Bench for te_sync_detect: directed corners plus seeded random frames,
// compared against an event-level model of the requirements.
module te_sync_detect_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te_pin = 1'b0;
    logic        cfg_te_en = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_hs_inv = 1'b0;
    logic        cfg_vs_inv = 1'b0;
    logic [2:0]  cfg_hs_width = 3'd0;
    logic [8:0]  cfg_vs_width = 9'd0;
    logic [10:0] cfg_line = 11'd0;
    logic        match_n;
    logic        hsync_evt;
    logic        vsync_evt;
    logic [10:0] cur_line;

    te_sync_detect uut (
        .clk(clk), .rst_n(rst_n), .te_pin(te_pin), .cfg_te_en(cfg_te_en),
        .cfg_mode(cfg_mode), .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
        .cfg_hs_width(cfg_hs_width), .cfg_vs_width(cfg_vs_width),
        .cfg_line(cfg_line), .match_n(match_n), .hsync_evt(hsync_evt),
        .vsync_evt(vsync_evt), .cur_line(cur_line)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int obs_hs = 0, obs_vs = 0, obs_m = 0, obs_dbl = 0;
    int exp_hs = 0, exp_vs = 0, exp_m = 0, exp_line = 0;
    bit prev_low = 0, first_run = 1, done = 0;
    logic cur_lvl = 1'b0;
    int cur_len = 0;

    // Observe output strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hsync_evt) obs_hs++;
            if (vsync_evt) obs_vs++;
            if (!match_n) begin
                obs_m++;
                if (prev_low) obs_dbl++;
            end
            prev_low = !match_n;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model: classify a finished run from the requirements.
    function automatic void end_run(logic lvl, int len);
        int hthr, vthr, l;
        bit m;
        hthr = int'(cfg_hs_width) + 1;
        vthr = (int'(cfg_vs_width) + 1) * 8;
        l = (len > 8191) ? 8191 : len;
        m = 0;
        if (first_run) begin
            first_run = 0;
            return;
        end
        if (lvl == !cfg_vs_inv && l >= vthr) begin
            exp_vs++;
            exp_line = 0;
            m = cfg_te_en && (cfg_mode == 2'b11 || (cfg_mode == 2'b10 && cfg_line == 0));
        end else if (lvl == !cfg_hs_inv && l >= hthr) begin
            exp_hs++;
            if (exp_line < 2047) exp_line++;
            m = cfg_te_en && cfg_mode == 2'b10 && exp_line == int'(cfg_line);
        end
        if (m) exp_m++;
    endfunction

    task automatic drive(logic lvl, int len);
        if (lvl != cur_lvl) begin
            end_run(cur_lvl, cur_len);
            cur_lvl = lvl;
            cur_len = 0;
        end
        te_pin = lvl;
        repeat (len) @(negedge clk);
        cur_len += len;
    endtask

    task automatic checkpoint(string tag);
        drive(cur_lvl, 8);
        chk({tag, " hsync count"}, obs_hs, exp_hs);
        chk({tag, " vsync count"}, obs_vs, exp_vs);
        chk({tag, " match count"}, obs_m, exp_m);
        chk({tag, " line"}, int'(cur_line), exp_line);
    endtask

    task automatic do_reset();
        te_pin = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        obs_hs = 0; obs_vs = 0; obs_m = 0; obs_dbl = 0; prev_low = 0;
        exp_hs = 0; exp_vs = 0; exp_m = 0; exp_line = 0;
        first_run = 1; cur_lvl = 1'b0; cur_len = 0;
    endtask

    task automatic set_cfg(bit en, logic [1:0] md, bit hi, bit vi,
                           logic [2:0] hw, logic [8:0] vw, logic [10:0] ln);
        cfg_te_en = en; cfg_mode = md; cfg_hs_inv = hi; cfg_vs_inv = vi;
        cfg_hs_width = hw; cfg_vs_width = vw; cfg_line = ln;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state.
        set_cfg(1, 2'b11, 0, 1, 3'd3, 9'd1, 11'd0);
        @(negedge clk);
        chk("R1 match_n in reset", int'(match_n), 1);
        do_reset();
        chk("R1 match_n", int'(match_n), 1);
        chk("R1 events", int'(hsync_evt) + int'(vsync_evt), 0);
        chk("R1 line", int'(cur_line), 0);

        // R11: long active-low vertical level from reset is not classified.
        drive(0, 60);
        drive(1, 10);
        checkpoint("R11");

        // R2/R7: vertical pulse with thresholds 4 and 16, vertical-only mode.
        do_reset();
        set_cfg(1, 2'b11, 0, 0, 3'd3, 9'd1, 11'd0);
        drive(0, 10);
        drive(1, 20);
        drive(0, 10);
        checkpoint("R2");
        // R3: horizontal pulses at and above the threshold; R7 no match on them.
        for (int i = 0; i < 3; i++) begin drive(1, 4 + i); drive(0, 5); end
        checkpoint("R3");
        // R4: glitch one tick below the horizontal threshold.
        drive(1, 3); drive(0, 5);
        drive(1, 1); drive(0, 5);
        checkpoint("R4");
        // R2/R3 boundary: 15 ticks is horizontal, 16 ticks vertical.
        drive(1, 15); drive(0, 5);
        checkpoint("R3 boundary");
        drive(1, 16); drive(0, 5);
        checkpoint("R2 boundary");

        // R8: line match at line 2, then at line 0.
        set_cfg(1, 2'b10, 0, 0, 3'd3, 9'd1, 11'd2);
        drive(1, 20); drive(0, 5);
        for (int i = 0; i < 3; i++) begin drive(1, 5); drive(0, 5); end
        checkpoint("R8 line2");
        cfg_line = 11'd0;
        drive(1, 20); drive(0, 5);
        drive(1, 5); drive(0, 5);
        checkpoint("R8 line0");

        // R9: mode off, reserved mode, and enable low.
        set_cfg(1, 2'b00, 0, 0, 3'd3, 9'd1, 11'd0);
        drive(1, 20); drive(0, 5); drive(1, 5); drive(0, 5);
        checkpoint("R9 mode0");
        cfg_mode = 2'b01;
        drive(1, 20); drive(0, 5);
        checkpoint("R9 mode1");
        set_cfg(0, 2'b11, 0, 0, 3'd3, 9'd1, 11'd0);
        drive(1, 20); drive(0, 5);
        checkpoint("R9 enable");

        // R5: both syncs active-low, then mixed polarity.
        set_cfg(1, 2'b11, 1, 1, 3'd3, 9'd1, 11'd0);
        drive(1, 12);
        drive(0, 20); drive(1, 6);
        drive(0, 5); drive(1, 6);
        drive(0, 2); drive(1, 30);
        checkpoint("R5 inverted");
        set_cfg(1, 2'b11, 1, 0, 3'd3, 9'd1, 11'd0);
        drive(0, 12);
        drive(1, 24); drive(0, 3);
        drive(1, 6); drive(0, 12);
        checkpoint("R5 mixed");

        // R6: saturation of the line counter and repeat matches at 2047.
        set_cfg(1, 2'b10, 0, 0, 3'd0, 9'd0, 11'd2047);
        drive(0, 8);
        drive(1, 10); drive(0, 3);
        for (int i = 0; i < 2050; i++) begin drive(1, 2); drive(0, 2); end
        checkpoint("R6 saturate");

        // R6/R8: seeded random frames with glitches, targets and polarities.
        for (int f = 0; f < 40; f++) begin
            bit inv;
            int vthr, hthr, nh;
            inv = 1'($urandom % 2);
            set_cfg(($urandom % 8) != 0, 2'($urandom % 4), inv, inv,
                    3'($urandom % 8), 9'($urandom % 4), 11'($urandom % 6));
            vthr = (int'(cfg_vs_width) + 1) * 8;
            hthr = int'(cfg_hs_width) + 1;
            drive(inv, 4);
            drive(!inv, vthr + int'($urandom % 5));
            drive(inv, 2 + int'($urandom % 4));
            nh = int'($urandom % 8);
            for (int h = 0; h < nh; h++) begin
                drive(!inv, 1 + int'($urandom % (vthr - 1)));
                drive(inv, 1 + int'($urandom % 6));
            end
            if (hthr > 1) begin drive(!inv, hthr - 1); drive(inv, 3); end
            checkpoint("R6 random");
        end

        // R10: no match pulse lasted longer than one cycle.
        chk("R10 match width", obs_dbl, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule